// File: doc/BRIEF.md
# Ripple-Carry Sliced Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit. It is built from identical one-bit cells that are stacked together, and a carry ripples from the least significant cell to the most significant one. It takes two operands and a three-bit operation code. It returns a result word, a carry-out, and two status bits: one shows a result of zero and the other shows a negative result.

Each cell holds a full adder made from two half adders, together with an AND gate and an OR gate. To subtract, the B operand is inverted and the carry into the lowest cell is forced to one. The signed less-than comparison reuses that subtract path and corrects the sign for overflow. A control sequencer can advance a program counter with this unit by issuing an add with B tied to 1. The carry-in port lets the add operation be chained across several units.

Top module: `bsalu_top`

## Requirements
- R1: With op code 0 (add), result = (A + B + carry_in) mod 2^16, and carry_out is bit 16 of that sum.
- R2: With op code 1 (subtract), result = (A - B) mod 2^16. carry_in is ignored, and carry_out is 1 exactly when A >= B as unsigned numbers.
- R3: With op code 2, result = A AND B bit by bit, and carry_out is 0.
- R4: With op code 3, result = A OR B bit by bit, and carry_out is 0.
- R5: With op code 4 (set-less-than), result is 16'h0001 when A < B as two's-complement signed values and 16'h0000 otherwise. carry_out is 0. This includes operand pairs whose difference overflows.
- R6: Op codes 5, 6 and 7 give a result of 0 and a carry_out of 0.
- R7: The zero flag is 1 exactly when all 16 result bits are 0.
- R8: The negative flag equals bit 15 of the result.
- R9: Incrementing a counter (add, B = 1, carry_in = 0) gives A + 1. For A = 16'hFFFF this wraps to 0 with carry_out = 1.
- R10: A carry_in of 1 passes through all 16 cells. For A = 16'hFFFF, B = 0 and add, the result is 0 and carry_out is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 slt |
| cin_i | input | 1 | Carry into the lowest cell (used by add only) |
| res_o | output | 16 | Result word |
| cout_o | output | 1 | Carry out of the highest cell for add and subtract, otherwise 0 |
| zero_o | output | 1 | High when the result is all zeros |
| neg_o | output | 1 | Copy of result bit 15 |

## Verification
The immediate assertions are evaluated every time an input changes. Each cell's two-half-adder sum is compared with the arithmetic sum of its inputs. The rippled add and subtract results are compared with a whole-word computation. The assertions also check that set-less-than produces only 0 or 1, and that both flags follow the result. Some points can only be shown by the bench's directed operands: the signed comparison across overflow boundaries, the wrap of the increment at all-ones, carry_in being ignored during subtract, and unused op codes clearing the outputs.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

    parameter int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } half_sum_t;

    typedef struct packed {
        logic sum;
        logic carry;
        logic land;
        logic lor;
    } cell_out_t;

    // B is complemented for every operation that subtracts
    function automatic logic uses_inverted_b(logic [2:0] code);
        return (code == OP_SUB) || (code == OP_SLT);
    endfunction

endpackage

// File: rtl/bsalu_half_add.sv
module bsalu_half_add
    import bsalu_pkg::*;
(
    input  logic      x_i,
    input  logic      y_i,
    output half_sum_t hs_o
);
    always_comb begin
        hs_o.sum   = x_i ^ y_i;
        hs_o.carry = x_i & y_i;
    end
endmodule

// File: rtl/bsalu_cell.sv
module bsalu_cell
    import bsalu_pkg::*;
(
    input  logic      a_i,
    input  logic      b_i,
    input  logic      binv_i,
    input  logic      cin_i,
    output cell_out_t cell_o
);
    logic      b_eff;
    half_sum_t first_hs;
    half_sum_t second_hs;

    assign b_eff = b_i ^ binv_i;

    bsalu_half_add u_ha_lo (.x_i(a_i),          .y_i(b_eff), .hs_o(first_hs));
    bsalu_half_add u_ha_hi (.x_i(first_hs.sum), .y_i(cin_i), .hs_o(second_hs));

    always_comb begin
        cell_o.sum   = second_hs.sum;
        cell_o.carry = first_hs.carry | second_hs.carry;
        cell_o.land  = a_i & b_i;
        cell_o.lor   = a_i | b_i;
    end

    // R1 at the cell level: two half adders make one full adder
    always_comb begin
        a_r1_cell_full_add: assert ({cell_o.carry, cell_o.sum} ==
                                    (2'(a_i) + 2'(b_eff) + 2'(cin_i)))
            else $error("cell full-add mismatch");
    end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags #(
    parameter int unsigned WIDTH = bsalu_pkg::WORD_W
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             zero_o,
    output logic             neg_o
);
    assign zero_o = ~(|res_i);
    assign neg_o  = res_i[WIDTH-1];
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
    import bsalu_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [2:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             zero_o,
    output logic             neg_o
);
    localparam int unsigned MSB  = WIDTH - 1;
    localparam int unsigned EXTW = WIDTH + 1;

    logic             binv;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sum_v, and_v, or_v;
    logic             ovf, less;

    assign binv     = uses_inverted_b(op_i);
    assign chain[0] = binv ? 1'b1 : ((op_i == OP_ADD) ? cin_i : 1'b0);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        cell_out_t co;
        bsalu_cell u_cell (
            .a_i   (opa_i[i]),
            .b_i   (opb_i[i]),
            .binv_i(binv),
            .cin_i (chain[i]),
            .cell_o(co)
        );
        assign sum_v[i]   = co.sum;
        assign and_v[i]   = co.land;
        assign or_v[i]    = co.lor;
        assign chain[i+1] = co.carry;
    end

    // signed compare from the difference, corrected for overflow
    assign ovf  = (opa_i[MSB] ^ opb_i[MSB]) & (sum_v[MSB] ^ opa_i[MSB]);
    assign less = sum_v[MSB] ^ ovf;

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        case (op_i)
            OP_ADD: begin res_o = sum_v; cout_o = chain[WIDTH]; end
            OP_SUB: begin res_o = sum_v; cout_o = chain[WIDTH]; end
            OP_AND: res_o = and_v;
            OP_OR:  res_o = or_v;
            OP_SLT: res_o = {{(WIDTH-1){1'b0}}, less};
            default: ;
        endcase
    end

    bsalu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i (res_o),
        .zero_o(zero_o),
        .neg_o (neg_o)
    );

    always_comb begin
        if (op_i == OP_ADD) begin
            a_r1_ripple_add: assert ({chain[WIDTH], sum_v} ==
                (EXTW'(opa_i) + EXTW'(opb_i) + EXTW'(cin_i)))
                else $error("ripple add mismatch");
        end
        if (op_i == OP_SUB) begin
            a_r2_ripple_sub: assert (sum_v == WIDTH'(opa_i - opb_i))
                else $error("ripple subtract mismatch");
        end
        if (op_i == OP_SLT) begin
            a_r5_slt_boolean: assert (res_o[WIDTH-1:1] == '0)
                else $error("slt result not boolean");
        end
        a_r7_zero_flag: assert (zero_o == (res_o == '0))
            else $error("zero flag wrong");
        a_r8_neg_flag: assert (neg_o == res_o[MSB])
            else $error("negative flag wrong");
    end
endmodule

// File: tb/bsalu_top_test.sv
module bsalu_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0, b = '0;
    logic [2:0]  op = '0;
    logic        cin = 1'b0;
    logic [15:0] res;
    logic        cout, zero, neg;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] y;
        logic        c;
        logic        z;
        logic        n;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    bsalu_top uut (
        .opa_i(a), .opb_i(b), .op_i(op), .cin_i(cin),
        .res_o(res), .cout_o(cout), .zero_o(zero), .neg_o(neg)
    );

    function automatic exp_t model(logic [15:0] x, logic [15:0] y,
                                   logic [2:0] code, logic ci);
        exp_t e;
        logic [16:0] wide;
        e.y = '0;
        e.c = 1'b0;
        case (code)
            3'd0: begin wide = {1'b0, x} + {1'b0, y} + {16'b0, ci}; e.y = wide[15:0]; e.c = wide[16]; end
            3'd1: begin e.y = x - y; e.c = (x >= y); end
            3'd2: e.y = x & y;
            3'd3: e.y = x | y;
            3'd4: e.y = ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
            default: ;
        endcase
        e.z = (e.y == 16'd0);
        e.n = e.y[15];
        return e;
    endfunction

    task automatic drive(logic [15:0] x, logic [15:0] y,
                         logic [2:0] code, logic ci, string tag);
        @(negedge clk);
        a = x; b = y; op = code; cin = ci;
        exp_q.push_back(model(x, y, code, ci));
        tag_q.push_back(tag);
    endtask

    // monitor: compare one queued expectation per rising edge
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (res !== e.y || cout !== e.c || zero !== e.z || neg !== e.n) begin
                n_bad++;
                $display("FAIL %s: got y=%h c=%b z=%b n=%b expected y=%h c=%b z=%b n=%b",
                         t, res, cout, zero, neg, e.y, e.c, e.z, e.n);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        drive(16'h0000, 16'h0000, 3'd0, 1'b0, "R7 reset-state zero");
        drive(16'h1234, 16'h4321, 3'd0, 1'b0, "R1 add");
        drive(16'h8000, 16'h8000, 3'd0, 1'b1, "R1 add carry");
        drive(16'hFFFF, 16'h0000, 3'd0, 1'b1, "R10 chain carry");
        drive(16'h00FF, 16'h0001, 3'd0, 1'b0, "R9 increment");
        drive(16'hFFFF, 16'h0001, 3'd0, 1'b0, "R9 increment wrap");
        drive(16'h0005, 16'h0007, 3'd1, 1'b0, "R2 sub borrow");
        drive(16'h0009, 16'h0004, 3'd1, 1'b1, "R2 sub cin ignored");
        drive(16'h7777, 16'h7777, 3'd1, 1'b0, "R2 sub equal");
        drive(16'hF0F0, 16'h3C3C, 3'd2, 1'b1, "R3 and");
        drive(16'hF0F0, 16'h3C3C, 3'd3, 1'b1, "R4 or");
        drive(16'hFFFE, 16'h0001, 3'd4, 1'b0, "R5 slt neg<pos");
        drive(16'h0001, 16'hFFFE, 3'd4, 1'b0, "R5 slt pos>neg");
        drive(16'h8000, 16'h7FFF, 3'd4, 1'b0, "R5 slt overflow min");
        drive(16'h7FFF, 16'h8000, 3'd4, 1'b0, "R5 slt overflow max");
        drive(16'h0003, 16'h0003, 3'd4, 1'b0, "R5 slt equal");
        drive(16'hAAAA, 16'h5555, 3'd5, 1'b1, "R6 code5");
        drive(16'hFFFF, 16'hFFFF, 3'd6, 1'b1, "R6 code6");
        drive(16'h1111, 16'h2222, 3'd7, 1'b0, "R6 code7");
        drive(16'h7000, 16'h2000, 3'd0, 1'b0, "R8 negative flag");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule